// File: doc/BRIEF.md
# Unsigned Array Multiplier

This block multiplies two unsigned N-bit operands and delivers the full 2N-bit product with no clock, no handshake and no pipeline register. It contains no behavioural multiply operator. The product comes from a square grid of identical cells. Each cell ANDs one bit of the multiplicand with one bit of the multiplier. It then adds that partial-product bit to an incoming partial sum and an incoming carry through a 1-bit full adder.

Each row of the grid handles one multiplier bit. Within a row, carries ripple from the least significant column to the most significant one. The row's sums, shifted down by one column, feed the next row. The row's final carry enters the top column of the next row. The top row receives zero partial sums and zero carries, so its cells only form AND terms.

Product bit i for i below N-1 is taken from the least significant sum of row i. The upper half of the product is formed from the last row's sums and that row's outgoing ripple carry.

The block is meant to sit inside a clocked datapath, with registers on both sides. The surrounding clock period must cover the worst-case carry path through the grid. That path grows roughly linearly with N.

Top module: `arrmul_grid`

## Requirements
- R1: For every pair of operands, `prod` equals the unsigned product `a_op * b_op` as a 2N-bit value. At the default N = 4, all 256 pairs are covered.
- R2: When either operand is zero, `prod` is zero in every bit.
- R3: A multiplier of 1 makes `prod` equal the multiplicand zero-extended. A multiplicand of 1 makes `prod` equal the multiplier zero-extended.
- R4: All-ones operands give `(2^N-1)^2`, which sets the most significant product bit. At N = 4 this is 0xE1.
- R5: The block is purely combinational. A change of operands is fully reflected on `prod` within the same clock period of the surrounding logic, with no clock edge in between.
- R6: The width parameter N may be set to any value from 2 to 8, and R1 to R4 hold at every such width. N = 8 is used as the wide corner, where 255 * 255 = 65025.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | N | Unsigned multiplicand |
| b_op | input | N | Unsigned multiplier; bit i controls grid row i |
| prod | output | 2N | Unsigned product |

## Verification
The main check sweeps every multiplicand and multiplier pair at N = 4. This exposes any misrouted shift between rows, a dropped row carry, or a wrong product bit tap. Zero operands, unit operands and all-ones operands are also applied on their own.

The zero and unit patterns tell apart a defect in the AND terms from one in the adder chain. The all-ones case drives the longest carry ripple and the top product bit.

A second instance at N = 8 is tried with its extreme operands and with a set of operands that spread across the range. These show that the generate structure scales and that no index is tied to the default width.

// File: rtl/arrmul_pkg.sv
package arrmul_pkg;

    // Result of a one-bit addition: weight-1 sum and weight-2 carry.
    typedef struct packed {
        logic carry;
        logic sum;
    } bit_add_t;

    localparam int unsigned MIN_WIDTH = 2;
    localparam int unsigned MAX_WIDTH = 8;

endpackage

// File: rtl/arrmul_fa.sv
module arrmul_fa
    import arrmul_pkg::*;
(
    input  logic     in_a,
    input  logic     in_b,
    input  logic     in_c,
    output bit_add_t res
);

    logic half_x;

    always_comb begin
        half_x    = in_a ^ in_b;
        res.sum   = half_x ^ in_c;
        res.carry = (in_a & in_b) | (half_x & in_c);
    end

endmodule

// File: rtl/arrmul_cell.sv
module arrmul_cell
    import arrmul_pkg::*;
(
    input  logic x_bit,
    input  logic y_bit,
    input  logic sum_in,
    input  logic carry_in,
    output logic pp_bit,
    output logic sum_out,
    output logic carry_out
);

    bit_add_t add_res;

    assign pp_bit = x_bit & y_bit;

    arrmul_fa u_fa (
        .in_a (pp_bit),
        .in_b (sum_in),
        .in_c (carry_in),
        .res  (add_res)
    );

    assign sum_out   = add_res.sum;
    assign carry_out = add_res.carry;

    // R1: a set partial-product bit always leaves a nonzero weight at the cell.
    always_comb begin
        if (!$isunknown({pp_bit, sum_out, carry_out}))
            p_pp_visible_r1: assert (!pp_bit || sum_out || carry_out)
                else $error("cell lost its partial-product bit");
    end

endmodule

// File: rtl/arrmul_row.sv
module arrmul_row #(
    parameter int unsigned N         = 4,
    parameter bit          FIRST_ROW = 1'b0
) (
    input  logic [N-1:0] mcand,
    input  logic         mplier_bit,
    input  logic [N-1:0] psum_in,
    output logic [N-1:0] psum_out,
    output logic         row_carry,
    output logic [N-1:0] pp_bits
);

    logic [N:0] chain;

    assign chain[0] = 1'b0;

    for (genvar j = 0; j < N; j++) begin : g_col
        arrmul_cell u_cell (
            .x_bit     (mcand[j]),
            .y_bit     (mplier_bit),
            .sum_in    (psum_in[j]),
            .carry_in  (chain[j]),
            .pp_bit    (pp_bits[j]),
            .sum_out   (psum_out[j]),
            .carry_out (chain[j+1])
        );
    end

    assign row_carry = chain[N];

    // R1: with no incoming partial sum the row reduces to plain AND terms.
    if (FIRST_ROW) begin : g_first_chk
        always_comb begin
            if (!$isunknown({psum_in, psum_out, pp_bits, row_carry}) && psum_in == '0)
                p_first_row_and_r1: assert (psum_out == pp_bits && !row_carry)
                    else $error("first row produced a carry");
        end
    end

endmodule

// File: rtl/arrmul_grid.sv
module arrmul_grid
    import arrmul_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0]   a_op,
    input  logic [N-1:0]   b_op,
    output logic [2*N-1:0] prod
);

    localparam int unsigned PW = 2 * N;
    localparam logic [PW-1:0] MAX_SQ = PW'(((1 << N) - 1) * ((1 << N) - 1));

    logic [N-1:0] row_sum [N];
    logic [N-1:0] row_in  [N];
    logic [N-1:0] row_pp  [N];
    logic         row_co  [N];

    for (genvar i = 0; i < N; i++) begin : g_row
        if (i == 0) begin : g_top
            assign row_in[i] = '0;
        end else begin : g_inner
            assign row_in[i] = {row_co[i-1], row_sum[i-1][N-1:1]};
        end

        arrmul_row #(
            .N         (N),
            .FIRST_ROW (i == 0)
        ) u_row (
            .mcand      (a_op),
            .mplier_bit (b_op[i]),
            .psum_in    (row_in[i]),
            .psum_out   (row_sum[i]),
            .row_carry  (row_co[i]),
            .pp_bits    (row_pp[i])
        );

        if (i < N - 1) begin : g_low_tap
            assign prod[i] = row_sum[i][0];
        end
    end

    assign prod[PW-2:N-1] = row_sum[N-1];
    assign prod[PW-1]     = row_co[N-1];

    always_comb begin
        if (!$isunknown({a_op, b_op, prod})) begin
            p_zero_operand_r2: assert (!(a_op == '0 || b_op == '0) || prod == '0)
                else $error("zero operand gave nonzero product");
            p_unit_mplier_r3: assert (b_op != N'(1) || prod == PW'(a_op))
                else $error("unit multiplier mismatch");
            p_unit_mcand_r3: assert (a_op != N'(1) || prod == PW'(b_op))
                else $error("unit multiplicand mismatch");
            p_max_square_r4: assert (!(&a_op && &b_op) || prod == MAX_SQ)
                else $error("all-ones square mismatch");
        end
    end

endmodule

// File: tb/tb_arrmul_grid.sv
module tb_arrmul_grid;

    localparam int unsigned N  = 4;
    localparam int unsigned NW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [N-1:0]    a_op, b_op;
    logic [2*N-1:0]  prod;
    logic [NW-1:0]   a_w, b_w;
    logic [2*NW-1:0] prod_w;

    int applied = 0;
    int misses  = 0;
    bit done    = 1'b0;

    arrmul_grid #(.N(N)) dut (
        .a_op (a_op),
        .b_op (b_op),
        .prod (prod)
    );

    arrmul_grid #(.N(NW)) dut_w8 (
        .a_op (a_w),
        .b_op (b_w),
        .prod (prod_w)
    );

    task automatic apply4(input int av, input int bv, input string req);
        int expv;
        @(posedge clk);
        #1;
        a_op = N'(av);
        b_op = N'(bv);
        expv = av * bv;
        @(negedge clk);
        applied++;
        if (prod !== (2*N)'(expv)) begin
            misses++;
            $display("FAIL %s: %0d*%0d actual %0d expected %0d", req, av, bv, prod, expv);
        end
    endtask

    task automatic apply8(input int av, input int bv, input string req);
        int expv;
        @(posedge clk);
        #1;
        a_w = NW'(av);
        b_w = NW'(bv);
        expv = av * bv;
        @(negedge clk);
        applied++;
        if (prod_w !== (2*NW)'(expv)) begin
            misses++;
            $display("FAIL %s: %0d*%0d actual %0d expected %0d", req, av, bv, prod_w, expv);
        end
    endtask

    initial begin
        a_op = '0; b_op = '0; a_w = '0; b_w = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: zero operands give zero product (R2)
        apply4(0, 0, "R2");
        // Boundary patterns
        for (int k = 0; k < 16; k++) apply4(k, 0, "R2");
        for (int k = 0; k < 16; k++) apply4(0, k, "R2");
        for (int k = 0; k < 16; k++) apply4(k, 1, "R3");
        for (int k = 0; k < 16; k++) apply4(1, k, "R3");
        apply4(15, 15, "R4");
        // Same-period response to back-to-back operand changes (R5)
        apply4(15, 15, "R5");
        apply4(7, 9, "R5");
        apply4(15, 15, "R5");
        // Exhaustive sweep (R1)
        for (int av = 0; av < 16; av++)
            for (int bv = 0; bv < 16; bv++)
                apply4(av, bv, "R1");
        // Wide instance (R6)
        apply8(255, 255, "R6");
        apply8(0, 200, "R6");
        apply8(1, 173, "R6");
        apply8(128, 128, "R6");
        apply8(170, 85, "R6");
        for (int k = 0; k < 256; k += 17) apply8(k, 255 - k, "R6");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
            $finish;
        end
    end

endmodule